// File: doc/BRIEF.md
# Serial-Number Isolation Engine

This block hands out small unique handles to a set of cards that share one open-drain line. Each card holds a fixed serial number of equal width. A host sequencer runs arbitration in rounds. In every bit slot, each card that is still competing drives the line for a 1 and releases it for a 0. The line reads high when any card drives it. A card that released the line but sees it high has lost and stays silent for the rest of that round. After the least significant bit, the one card still competing has the largest serial number among the cards without a handle. It receives the next handle and never competes again. Every other card without a handle joins the next round.

Handles are given out as 1, 2, 3 and so on. The process stops after a round in which no card drove the line in any bit slot. Each bit slot takes two clocks: a drive clock, then a sample clock. One round therefore lasts `2*SN_W + 2` clocks, and the final empty round lasts `2*SN_W + 1` clocks before the engine reports completion. Reset is asynchronous and active low. It is released through a two-stage synchronizer, and it clears every handle.

Top module: `iso_engine`

## Requirements
- R1: While reset is held, and after it is released, every handle reads 0, every assigned flag is 0, and `busy_o`, `done_o` and `line_o` are 0.
- R2: A `start_i` pulse seen in the idle state raises `busy_o` from the next clock. While the engine is busy or done, `start_i` has no effect: handles, assigned flags and `done_o` stay unchanged.
- R3: `line_o` is high only during the sample clock of a bit slot, and only when at least one competing card drives a 1 in that slot. It is low whenever the engine is idle or done.
- R4: Serial numbers are sent most significant bit first. A competing card that sends 0 while the line reads 1 stops competing until the round ends. Exactly one card remains at the end of a round in which some card drove the line. This holds because serial numbers are distinct.
- R5: Handles are given in increasing order from 1. The card with the largest serial number gets handle 1, the next largest gets 2, and so on. A decision made only at bit 0 follows the same rule.
- R6: A card that holds a handle keeps it, never drives the line again and never competes again. Cards that lost a round compete again in the next round, so every card with a nonzero serial number ends up holding a handle.
- R7: A card whose serial number is all zeros never drives the line. It never receives a handle, and its handle reads 0.
- R8: With K cards that have nonzero serial numbers, `done_o` rises exactly `K*(2*SN_W+2) + 2*SN_W + 1` clocks after the clock edge that accepts `start_i`. At the same moment `busy_o` falls. `done_o` then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse that begins isolation from the idle state |
| serials_i | input | NUM_CARDS*SN_W | Serial numbers; card i uses bits [i*SN_W +: SN_W]. Must be held stable while busy |
| line_o | output | 1 | Value of the shared open-drain line |
| busy_o | output | 1 | Isolation in progress |
| done_o | output | 1 | Isolation finished |
| assigned_o | output | NUM_CARDS | Per-card flag: handle held |
| handles_o | output | NUM_CARDS*HANDLE_W | Per-card handle; card i uses bits [i*HANDLE_W +: HANDLE_W] |

## Verification
The bench builds the engine with its defaults: four cards, 16-bit serial numbers and 4-bit handles. With these values, four arbitration rounds plus a final empty round are within reach, and so is the exact cycle count at which completion is reported. The serial sets are chosen so that the rounds are decided in different places. One set is decided in the upper bits. Another differs only in the two lowest bits, so the decisions happen on the final slots. A third contains an all-zero serial number and the all-ones value. A last scenario pulses start again after completion, to show that the pulse changes nothing.

// File: rtl/iso_pkg.sv
package iso_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_ROUND,
    SEQ_DRIVE,
    SEQ_SAMPLE,
    SEQ_GRANT,
    SEQ_DONE
  } seq_state_e;

  typedef struct packed {
    logic rejoin;   // new round: unassigned cards compete again
    logic drive;    // drive clock of a bit slot
    logic sample;   // sample clock of a bit slot
    logic grant;    // round winner takes the offered handle
  } slot_ctl_t;

endpackage

// File: rtl/iso_wired_or.sv
module iso_wired_or #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] drive_i,
  output logic         line_o
);

  logic [N:0] chain;

  assign chain[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_pull
    assign chain[g+1] = chain[g] | drive_i[g];
  end

  assign line_o = chain[N];

endmodule

// File: rtl/iso_sequencer.sv
module iso_sequencer
  import iso_pkg::*;
#(
  parameter int unsigned SN_W     = 16,
  parameter int unsigned HANDLE_W = 4,
  parameter int unsigned IDX_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                line_i,
  output slot_ctl_t           ctl_o,
  output logic [IDX_W-1:0]    bit_idx_o,
  output logic [HANDLE_W-1:0] handle_o,
  output logic                busy_o,
  output logic                done_o
);

  localparam logic [IDX_W-1:0] TOP_BIT = IDX_W'(SN_W - 1);

  seq_state_e          state_q, state_d;
  logic [IDX_W-1:0]    idx_q, idx_d;
  logic [HANDLE_W-1:0] hnd_q, hnd_d;
  logic                seen_q, seen_d;
  logic                seen_now;

  assign seen_now = seen_q | line_i;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    hnd_d   = hnd_q;
    seen_d  = seen_q;
    unique case (state_q)
      SEQ_IDLE: begin
        if (start_i) state_d = SEQ_ROUND;
      end
      SEQ_ROUND: begin
        idx_d   = TOP_BIT;
        seen_d  = 1'b0;
        state_d = SEQ_DRIVE;
      end
      SEQ_DRIVE: begin
        state_d = SEQ_SAMPLE;
      end
      SEQ_SAMPLE: begin
        seen_d = seen_now;
        if (idx_q == '0) begin
          state_d = seen_now ? SEQ_GRANT : SEQ_DONE;
        end else begin
          idx_d   = idx_q - 1'b1;
          state_d = SEQ_DRIVE;
        end
      end
      SEQ_GRANT: begin
        hnd_d   = hnd_q + 1'b1;
        state_d = SEQ_ROUND;
      end
      SEQ_DONE: begin
        state_d = SEQ_DONE;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      hnd_q   <= HANDLE_W'(1);
      seen_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      hnd_q   <= hnd_d;
      seen_q  <= seen_d;
    end
  end

  assign ctl_o.rejoin = (state_q == SEQ_ROUND);
  assign ctl_o.drive  = (state_q == SEQ_DRIVE);
  assign ctl_o.sample = (state_q == SEQ_SAMPLE);
  assign ctl_o.grant  = (state_q == SEQ_GRANT);
  assign bit_idx_o    = idx_q;
  assign handle_o     = hnd_q;
  assign busy_o       = (state_q != SEQ_IDLE) && (state_q != SEQ_DONE);
  assign done_o       = (state_q == SEQ_DONE);

  AST_LINE_ONLY_IN_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    line_i |-> (state_q == SEQ_SAMPLE)); // R3

  AST_HANDLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_GRANT) |=> (hnd_q == HANDLE_W'($past(hnd_q) + 1'b1))); // R5

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (done_o && !busy_o)); // R8

endmodule

// File: rtl/iso_card.sv
module iso_card
  import iso_pkg::*;
#(
  parameter int unsigned SN_W     = 16,
  parameter int unsigned HANDLE_W = 4,
  parameter int unsigned IDX_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SN_W-1:0]     serial_i,
  input  slot_ctl_t           ctl_i,
  input  logic [IDX_W-1:0]    bit_idx_i,
  input  logic                line_i,
  input  logic [HANDLE_W-1:0] handle_i,
  output logic                drive_o,
  output logic                active_o,
  output logic                assigned_o,
  output logic [HANDLE_W-1:0] handle_o
);

  logic                active_q, active_d;
  logic                owned_q, owned_d;
  logic                drv_q, drv_d;
  logic [HANDLE_W-1:0] hnd_q, hnd_d;
  logic                lost;

  // released the line for a 0 but the line reads 1
  assign lost = ctl_i.sample && active_q && !drv_q && line_i;

  always_comb begin
    active_d = active_q;
    owned_d  = owned_q;
    hnd_d    = hnd_q;
    drv_d    = 1'b0;
    if (ctl_i.rejoin && !owned_q) active_d = 1'b1;
    if (ctl_i.drive) drv_d = active_q && serial_i[bit_idx_i];
    if (lost) active_d = 1'b0;
    if (ctl_i.grant && active_q) begin
      owned_d  = 1'b1;
      hnd_d    = handle_i;
      active_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      owned_q  <= 1'b0;
      drv_q    <= 1'b0;
      hnd_q    <= '0;
    end else begin
      active_q <= active_d;
      owned_q  <= owned_d;
      drv_q    <= drv_d;
      hnd_q    <= hnd_d;
    end
  end

  assign drive_o    = drv_q;
  assign active_o   = active_q;
  assign assigned_o = owned_q;
  assign handle_o   = hnd_q;

  AST_LOSER_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_i.sample && active_q && !drv_q && line_i) |=> !active_q); // R4

  AST_RETIRED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    owned_q |-> (!drv_q && !active_q)); // R6

  AST_HANDLE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    owned_q |=> (owned_q && $stable(hnd_q))); // R6

  AST_ZERO_NEVER_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (serial_i == '0) |-> !drv_q); // R7

endmodule

// File: rtl/iso_engine.sv
module iso_engine
  import iso_pkg::*;
#(
  parameter int unsigned NUM_CARDS = 4,
  parameter int unsigned SN_W      = 16,
  parameter int unsigned HANDLE_W  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic [NUM_CARDS*SN_W-1:0]     serials_i,
  output logic                          line_o,
  output logic                          busy_o,
  output logic                          done_o,
  output logic [NUM_CARDS-1:0]          assigned_o,
  output logic [NUM_CARDS*HANDLE_W-1:0] handles_o
);

  localparam int unsigned IDX_W = (SN_W > 1) ? $clog2(SN_W) : 1;

  logic [1:0]           rst_pipe_q;
  logic                 rst_sync_n;
  slot_ctl_t            ctl;
  logic [IDX_W-1:0]     bit_idx;
  logic [HANDLE_W-1:0]  offer;
  logic [NUM_CARDS-1:0] drives;
  logic [NUM_CARDS-1:0] actives;
  logic                 line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  iso_sequencer #(
    .SN_W(SN_W), .HANDLE_W(HANDLE_W), .IDX_W(IDX_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .start_i(start_i), .line_i(line),
    .ctl_o(ctl), .bit_idx_o(bit_idx), .handle_o(offer),
    .busy_o(busy_o), .done_o(done_o)
  );

  for (genvar c = 0; c < NUM_CARDS; c++) begin : g_card
    iso_card #(
      .SN_W(SN_W), .HANDLE_W(HANDLE_W), .IDX_W(IDX_W)
    ) u_card (
      .clk(clk), .rst_n(rst_sync_n),
      .serial_i(serials_i[c*SN_W +: SN_W]),
      .ctl_i(ctl), .bit_idx_i(bit_idx), .line_i(line), .handle_i(offer),
      .drive_o(drives[c]), .active_o(actives[c]),
      .assigned_o(assigned_o[c]),
      .handle_o(handles_o[c*HANDLE_W +: HANDLE_W])
    );
  end

  iso_wired_or #(.N(NUM_CARDS)) u_bus (.drive_i(drives), .line_o(line));

  assign line_o = line;

  AST_SINGLE_WINNER: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ctl.grant |-> ($countones(actives) == 1)); // R4

  AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy_o) |-> !line_o); // R3

endmodule

// File: tb/iso_engine_test.sv
module iso_engine_test;

  localparam int N   = 4;
  localparam int SW  = 16;
  localparam int HW  = 4;
  localparam int RND = 2 * SW + 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start;
  logic [N*SW-1:0]   serials;
  logic              line_w;
  logic              busy_w;
  logic              done_w;
  logic [N-1:0]      assigned_w;
  logic [N*HW-1:0]   handles_w;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  iso_engine #(.NUM_CARDS(N), .SN_W(SW), .HANDLE_W(HW)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .serials_i(serials),
    .line_o(line_w), .busy_o(busy_w), .done_o(done_w),
    .assigned_o(assigned_w), .handles_o(handles_w)
  );

  task automatic check(input string req, input string what,
                       input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
    end
  endtask

  function automatic int exp_handle(input logic [N*SW-1:0] s, input int i);
    int r;
    if (s[i*SW +: SW] == '0) return 0;
    r = 1;
    for (int j = 0; j < N; j++)
      if (s[j*SW +: SW] > s[i*SW +: SW]) r++;
    return r;
  endfunction

  task automatic apply_reset(input logic [N*SW-1:0] s);
    @(negedge clk);
    rst_n   = 1'b0;
    start   = 1'b0;
    serials = s;
    repeat (2) @(negedge clk);
    check("R1", "assigned in reset", int'(assigned_w), 0);
    check("R1", "busy/done/line in reset", int'({busy_w, done_w, line_w}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "handles after reset", int'(handles_w), 0);
    check("R1", "busy/done/line after reset", int'({busy_w, done_w, line_w}), 0);
  endtask

  // runs one isolation and checks timing, handles and flags
  task automatic run_and_check(input string name, input logic [N*SW-1:0] s);
    int k;
    int nz;
    int expd;
    apply_reset(s);
    nz = 0;
    for (int i = 0; i < N; i++) if (s[i*SW +: SW] != '0) nz++;
    expd = nz * RND + 2 * SW + 1;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check("R2", {name, " busy after start"}, int'(busy_w), 1);
    k = 0;
    while (!done_w && k < expd + 20) begin
      @(posedge clk);
      k++;
      @(negedge clk);
    end
    check("R8", {name, " cycles to done"}, k, expd);
    check("R8", {name, " busy low at done"}, int'(busy_w), 0);
    check("R3", {name, " line low when done"}, int'(line_w), 0);
    for (int i = 0; i < N; i++) begin
      int e;
      e = exp_handle(s, i);
      if (e == 0) begin
        check("R7", {name, " zero serial handle"}, int'(handles_w[i*HW +: HW]), 0);
        check("R7", {name, " zero serial unassigned"}, int'(assigned_w[i]), 0);
      end else begin
        check("R5", {name, " handle order"}, int'(handles_w[i*HW +: HW]), e);
        check("R6", {name, " assigned flag"}, int'(assigned_w[i]), 1);
      end
    end
    repeat (3) @(negedge clk);
    check("R8", {name, " done stays"}, int'(done_w), 1);
  endtask

  task automatic t_spread();
    // decided in the upper bits
    run_and_check("spread", {16'h0F0F, 16'hF00F, 16'h1234, 16'hA5A5});
  endtask

  task automatic t_low_bits();
    // R4: decisions fall on bits 1 and 0 only
    run_and_check("lowbits", {16'h8002, 16'h8003, 16'h8000, 16'h8001});
  endtask

  task automatic t_zero_card();
    // R7: one all-zero card plus extremes
    run_and_check("zero", {16'h7FFF, 16'hFFFF, 16'h0001, 16'h0000});
  endtask

  task automatic t_restart_ignored();
    logic [N*HW-1:0] h0;
    logic [N-1:0]    a0;
    run_and_check("restart", {16'h0003, 16'h0300, 16'h3000, 16'h0030});
    h0 = handles_w;
    a0 = assigned_w;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (40) begin
      @(negedge clk);
      check("R3", "line low after ignored start", int'(line_w), 0);
    end
    check("R2", "handles unchanged by late start", int'(handles_w), int'(h0));
    check("R2", "assigned unchanged by late start", int'(assigned_w), int'(a0));
    check("R2", "done/busy unchanged by late start", int'({done_w, busy_w}), 2);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    rst_n   = 1'b0;
    start   = 1'b0;
    serials = '0;
    t_spread();
    t_low_bits();
    t_zero_card();
    t_restart_ignored();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule